// File: doc/BRIEF.md
# Runaway-Code Trap: Stack Pointer and Fill-Pattern Responder

This block sits beside the core of a small 8-bit controller and catches code that has lost its way. It keeps the RAM stack pointer and the stack bytes. The pointer moves down on call, interrupt and push, and moves up on return and pop. Two kinds of memory are never populated: RAM outside the stack area, and program memory outside the programmed range. Reads of either return a fixed byte, chosen so that the core falls into a software interrupt without any address comparator in the core itself.

Unprogrammed program memory reads as `0x00`, which is the software-interrupt opcode. Unpopulated RAM reads as `0xFF`. A return made with an empty stack therefore pops two `0xFF` bytes and vectors to the all-ones program address. The option register lives at that address, and an instruction fetch from it also yields `0x00`. A raised trap sets a pending flag that stays set until the core issues an explicit clear. A 2-bit cause code tells the recovery routine which of the two faults happened.

Top module: `runaway_guard`

## Requirements
- R1: After a synchronous active-low reset, `sp` is `0x6F`, `swi_pend` is 0, `swi_cause` is `00`, and `opcode`, `rd_data` and `ret_pc` are zero.
- R2: A push writes `push_data` at offset `sp` and lowers `sp` by 1. A pop raises `sp` by 1 and returns the byte at the new `sp` on `rd_data` one cycle later (last in, first out).
- R3: A call or an interrupt stores `pc_addr` as two bytes: the high byte, zero-extended, at offset `sp` and the low byte at `sp-1`. It then lowers `sp` by 2. A return reads the low byte from `sp+1` and the high byte from `sp+2`, raises `sp` by 2, and drives `ret_pc` to `{high[6:0], low}`.
- R4: A data read decodes `rd_addr` as `{segment[10:7], offset[6:0]}`. Segment 0, offsets `0x00`-`0x6F`, returns the stored stack byte. Segment 0, offsets `0x70`-`0x7F`, returns `0xFF`. Segments 1 to 3 return `0x00`, because they are populated but not stored in this block. Segments 4 to 15 return `0xFF`.
- R5: A fetch at or below `PROG_TOP` (default `0x3FFF`) returns `pm_data` on `opcode` one cycle later and does not raise the trap.
- R6: A fetch above `PROG_TOP` that is not `0x7FFF` returns `0x00`, sets `swi_pend`, and sets the cause to `01` (unprogrammed fetch).
- R7: A fetch at `0x7FFF` returns `0x00` and sets `swi_pend`. The cause is `10` (over-pop) if the over-pop flag is set, and `01` otherwise.
- R8: A pop or return that leaves `sp` above `0x6F` sets a sticky over-pop flag. A return made with an empty stack yields `ret_pc = 0x7FFF`.
- R9: Only reset or a software write of the stack pointer clears the over-pop flag.
- R10: `swi_pend` and `swi_cause` hold until `op_rpnd` clears them both to zero. If a trap fires while a trap is already pending, the first cause is kept. If a trap fires in the same cycle as `op_rpnd`, the pending flag stays set and the new cause is recorded.
- R11: A stack write whose offset is `0x70` or above is dropped, and that offset still reads `0xFF`.
- R12: `sp_wr` loads `sp_wdata` into `sp`. At most one of call, interrupt, return, push, pop, data read or `sp_wr` is active in a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_call | input | 1 | Subroutine call: stack `pc_addr` |
| op_intr | input | 1 | Interrupt entry: stack `pc_addr` |
| op_ret | input | 1 | Return: pop two bytes into `ret_pc` |
| op_push | input | 1 | Push `push_data` |
| op_pop | input | 1 | Pop one byte to `rd_data` |
| op_rd | input | 1 | Data read at `rd_addr` |
| op_fetch | input | 1 | Instruction fetch at `pc_addr` |
| op_rpnd | input | 1 | Clear the pending trap |
| sp_wr | input | 1 | Software write of the stack pointer |
| sp_wdata | input | 8 | New stack pointer value |
| push_data | input | 8 | Byte to push |
| pc_addr | input | 15 | Program address for fetch, call and interrupt |
| rd_addr | input | 11 | Data address `{segment, offset}` |
| pm_data | input | 8 | Byte from the programmed program array |
| opcode | output | 8 | Fetched byte |
| rd_data | output | 8 | Byte from a data read or pop |
| ret_pc | output | 15 | Address popped by the last return |
| sp | output | 8 | Stack pointer |
| swi_pend | output | 1 | Software-interrupt pending |
| swi_cause | output | 2 | Trap cause: 00 none, 01 unprogrammed, 10 over-pop |

## Verification
The bench drives returns and pops on an empty stack and confirms that the popped address is all ones. A design that clipped the pointer, or read stale RAM there, would send the core somewhere other than the trap. It fetches `0x7FFF` both with and without the over-pop flag, and again after a pointer rewrite and after a reset, so a flag that never clears, or a cause that ignores the flag, shows up as the wrong code. It also checks that the pending flag holds through further fetches and through a clear issued in the same cycle as a new trap, and that pushes at offsets above the stack area leave those offsets reading `0xFF`. A design that let such writes through would return the pushed byte instead.

// File: rtl/rg_pkg.sv
// Shared types and widths for the runaway-code trap.
// Assumes byte-wide memory and a 2-bit trap cause.
package rg_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        CAUSE_NONE    = 2'b00,
        CAUSE_UNPROG  = 2'b01,
        CAUSE_OVERPOP = 2'b10
    } cause_e;
endpackage

// File: rtl/rg_stack_ram.sv
// Stack byte store with two write ports and a data-read decoder.
// Assumes the stack occupies segment 0 offsets below STACK_END, writes
// outside that range are dropped, and unpopulated space reads all ones.
module rg_stack_ram #(
    parameter int              SP_W      = 8,
    parameter int              SEG_W     = 4,
    parameter int              OFF_W     = 7,
    parameter logic [SP_W-1:0] STACK_END = 8'h70,
    parameter logic [SEG_W-1:0] POP_SEGS = 4'd4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wa_en,
    input  logic [SP_W-1:0]          wa_addr,
    input  logic [7:0]               wa_data,
    input  logic                     wb_en,
    input  logic [SP_W-1:0]          wb_addr,
    input  logic [7:0]               wb_data,
    input  logic [SP_W-1:0]          ra_addr,
    output logic [7:0]               ra_data,
    input  logic [SP_W-1:0]          rb_addr,
    output logic [7:0]               rb_data,
    input  logic [SEG_W+OFF_W-1:0]   rc_addr,
    output logic [7:0]               rc_data
);
    localparam int DEPTH = int'(STACK_END);
    localparam int IDX_W = $clog2(DEPTH);

    logic [7:0] mem [DEPTH];

    // Read one stack offset, filling unpopulated offsets with ones.
    function automatic logic [7:0] stack_byte(input logic [SP_W-1:0] off);
        if (off < STACK_END) return mem[off[IDX_W-1:0]];
        return 8'hFF;
    endfunction

    // Store stack bytes; out-of-range writes are discarded.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (wa_en && wa_addr < STACK_END) mem[wa_addr[IDX_W-1:0]] <= wa_data;
            if (wb_en && wb_addr < STACK_END) mem[wb_addr[IDX_W-1:0]] <= wb_data;
        end
    end

    // Stack read ports used by pop and return.
    always_comb begin
        ra_data = stack_byte(ra_addr);
        rb_data = stack_byte(rb_addr);
    end

    // Data-read decoder over segment and offset.
    logic [SEG_W-1:0] rc_seg;
    logic [OFF_W-1:0] rc_off;
    always_comb begin
        rc_seg = rc_addr[SEG_W+OFF_W-1:OFF_W];
        rc_off = rc_addr[OFF_W-1:0];
        if (rc_seg == '0)          rc_data = stack_byte(SP_W'(rc_off));
        else if (rc_seg < POP_SEGS) rc_data = 8'h00;
        else                       rc_data = 8'hFF;
    end
endmodule

// File: rtl/rg_sp_ctrl.sv
// Stack pointer, over-pop flag and the registered pop/return results.
// Assumes at most one stack strobe per cycle; high byte is pushed first.
module rg_sp_ctrl #(
    parameter int              SP_W    = 8,
    parameter int              PC_W    = 15,
    parameter logic [SP_W-1:0] SP_INIT = 8'h6F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_call,
    input  logic              op_intr,
    input  logic              op_ret,
    input  logic              op_push,
    input  logic              op_pop,
    input  logic              op_rd,
    input  logic              sp_wr,
    input  logic [SP_W-1:0]   sp_wdata,
    input  logic [7:0]        push_data,
    input  logic [PC_W-1:0]   pc_addr,
    input  logic [7:0]        ra_data,
    input  logic [7:0]        rb_data,
    input  logic [7:0]        rc_data,
    output logic              wa_en,
    output logic [SP_W-1:0]   wa_addr,
    output logic [7:0]        wa_data,
    output logic              wb_en,
    output logic [SP_W-1:0]   wb_addr,
    output logic [7:0]        wb_data,
    output logic [SP_W-1:0]   ra_addr,
    output logic [SP_W-1:0]   rb_addr,
    output logic [SP_W-1:0]   sp_q,
    output logic              overpop_q,
    output logic [7:0]        rd_data_q,
    output logic [PC_W-1:0]   ret_pc_q
);
    logic            stack_addr;
    logic [SP_W:0]   up1, up2;

    // Neighbour offsets and widened sums for the over-pop compare.
    always_comb begin
        stack_addr = op_call | op_intr;
        up1        = {1'b0, sp_q} + (SP_W+1)'(1);
        up2        = {1'b0, sp_q} + (SP_W+1)'(2);
        ra_addr    = up1[SP_W-1:0];
        rb_addr    = up2[SP_W-1:0];
    end

    // Write-port steering for call, interrupt and push.
    always_comb begin
        wa_en   = stack_addr | op_push;
        wa_addr = sp_q;
        wa_data = stack_addr ? 8'(pc_addr >> 8) : push_data;
        wb_en   = stack_addr;
        wb_addr = sp_q - 1'b1;
        wb_data = pc_addr[7:0];
    end

    // Stack pointer and sticky over-pop flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q      <= SP_INIT;
            overpop_q <= 1'b0;
        end else if (sp_wr) begin
            sp_q      <= sp_wdata;
            overpop_q <= 1'b0;
        end else if (stack_addr) begin
            sp_q <= sp_q - 2'd2;
        end else if (op_ret) begin
            sp_q <= up2[SP_W-1:0];
            if (up2 > {1'b0, SP_INIT}) overpop_q <= 1'b1;
        end else if (op_push) begin
            sp_q <= sp_q - 1'b1;
        end else if (op_pop) begin
            sp_q <= up1[SP_W-1:0];
            if (up1 > {1'b0, SP_INIT}) overpop_q <= 1'b1;
        end
    end

    // Registered results of pops, data reads and returns.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data_q <= '0;
            ret_pc_q  <= '0;
        end else begin
            if (op_pop)     rd_data_q <= ra_data;
            else if (op_rd) rd_data_q <= rc_data;
            if (op_ret)     ret_pc_q  <= PC_W'({rb_data, ra_data});
        end
    end

    a_r1_reset_sp: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> sp_q == SP_INIT);
    a_r12_single_op: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({op_call, op_intr, op_ret, op_push, op_pop, op_rd, sp_wr}));
    a_r2_push_down: assert property (@(posedge clk) disable iff (!rst_n)
        op_push |=> sp_q == $past(sp_q) - 1'b1);
    a_r3_ret_up: assert property (@(posedge clk) disable iff (!rst_n)
        op_ret |=> sp_q == $past(sp_q) + 2'd2);
    a_r8_overpop_set: assert property (@(posedge clk) disable iff (!rst_n)
        (op_pop && sp_q >= SP_INIT && sp_q != '1) |=> overpop_q);
    a_r9_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
        sp_wr |=> !overpop_q);
endmodule

// File: rtl/rg_fetch_guard.sv
// Instruction-fetch responder and software-interrupt pending logic.
// Assumes PROG_TOP lies below OPT_ADDR; forced fetches return 0x00.
module rg_fetch_guard
    import rg_pkg::*;
#(
    parameter int              PC_W     = 15,
    parameter logic [PC_W-1:0] PROG_TOP = 15'h3FFF,
    parameter logic [PC_W-1:0] OPT_ADDR = '1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            op_fetch,
    input  logic [PC_W-1:0] pc_addr,
    input  logic [7:0]      pm_data,
    input  logic            op_rpnd,
    input  logic            overpop,
    output logic [7:0]      opcode_q,
    output logic            pend_q,
    output cause_e          cause_q
);
    logic   at_opt, trap;
    cause_e new_cause;

    // Classify the current fetch.
    always_comb begin
        at_opt    = pc_addr == OPT_ADDR;
        trap      = op_fetch && (at_opt || pc_addr > PROG_TOP);
        new_cause = (at_opt && overpop) ? CAUSE_OVERPOP : CAUSE_UNPROG;
    end

    // Fetched byte: array contents or the forced trap opcode.
    always_ff @(posedge clk) begin
        if (!rst_n)        opcode_q <= '0;
        else if (op_fetch) opcode_q <= trap ? 8'h00 : pm_data;
    end

    // Pending flag and first cause, cleared only by the clear command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q  <= 1'b0;
            cause_q <= CAUSE_NONE;
        end else if (trap) begin
            pend_q <= 1'b1;
            if (!pend_q || op_rpnd) cause_q <= new_cause;
        end else if (op_rpnd) begin
            pend_q  <= 1'b0;
            cause_q <= CAUSE_NONE;
        end
    end

    a_r5_prog_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (op_fetch && pc_addr <= PROG_TOP) |=> opcode_q == $past(pm_data));
    a_r6_unprog_trap: assert property (@(posedge clk) disable iff (!rst_n)
        (op_fetch && pc_addr > PROG_TOP) |=> (opcode_q == 8'h00 && pend_q));
    a_r7_overpop_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (op_fetch && at_opt && overpop && !pend_q) |=> cause_q == CAUSE_OVERPOP);
    a_r10_pend_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !op_rpnd) |=> (pend_q && $stable(cause_q)));
endmodule

// File: rtl/runaway_guard.sv
// Top of the runaway-code trap: stack pointer, stack store, fill-pattern
// responder and trap pending logic. Assumes one stack strobe per cycle.
module runaway_guard
    import rg_pkg::*;
#(
    parameter int               PC_W      = 15,
    parameter int               SP_W      = 8,
    parameter int               SEG_W     = 4,
    parameter int               OFF_W     = 7,
    parameter logic [SP_W-1:0]  SP_INIT   = 8'h6F,
    parameter logic [SP_W-1:0]  STACK_END = 8'h70,
    parameter logic [SEG_W-1:0] POP_SEGS  = 4'd4,
    parameter logic [PC_W-1:0]  PROG_TOP  = 15'h3FFF
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   op_call,
    input  logic                   op_intr,
    input  logic                   op_ret,
    input  logic                   op_push,
    input  logic                   op_pop,
    input  logic                   op_rd,
    input  logic                   op_fetch,
    input  logic                   op_rpnd,
    input  logic                   sp_wr,
    input  logic [SP_W-1:0]        sp_wdata,
    input  logic [7:0]             push_data,
    input  logic [PC_W-1:0]        pc_addr,
    input  logic [SEG_W+OFF_W-1:0] rd_addr,
    input  logic [7:0]             pm_data,
    output logic [7:0]             opcode,
    output logic [7:0]             rd_data,
    output logic [PC_W-1:0]        ret_pc,
    output logic [SP_W-1:0]        sp,
    output logic                   swi_pend,
    output logic [1:0]             swi_cause
);
    logic            wa_en, wb_en, overpop;
    logic [SP_W-1:0] wa_addr, wb_addr, ra_addr, rb_addr;
    logic [7:0]      wa_data, wb_data, ra_data, rb_data, rc_data;
    cause_e          cause;

    rg_stack_ram #(
        .SP_W(SP_W), .SEG_W(SEG_W), .OFF_W(OFF_W),
        .STACK_END(STACK_END), .POP_SEGS(POP_SEGS)
    ) u_ram (
        .clk(clk), .rst_n(rst_n),
        .wa_en(wa_en), .wa_addr(wa_addr), .wa_data(wa_data),
        .wb_en(wb_en), .wb_addr(wb_addr), .wb_data(wb_data),
        .ra_addr(ra_addr), .ra_data(ra_data),
        .rb_addr(rb_addr), .rb_data(rb_data),
        .rc_addr(rd_addr), .rc_data(rc_data)
    );

    rg_sp_ctrl #(.SP_W(SP_W), .PC_W(PC_W), .SP_INIT(SP_INIT)) u_sp (
        .clk(clk), .rst_n(rst_n),
        .op_call(op_call), .op_intr(op_intr), .op_ret(op_ret),
        .op_push(op_push), .op_pop(op_pop), .op_rd(op_rd),
        .sp_wr(sp_wr), .sp_wdata(sp_wdata), .push_data(push_data),
        .pc_addr(pc_addr),
        .ra_data(ra_data), .rb_data(rb_data), .rc_data(rc_data),
        .wa_en(wa_en), .wa_addr(wa_addr), .wa_data(wa_data),
        .wb_en(wb_en), .wb_addr(wb_addr), .wb_data(wb_data),
        .ra_addr(ra_addr), .rb_addr(rb_addr),
        .sp_q(sp), .overpop_q(overpop),
        .rd_data_q(rd_data), .ret_pc_q(ret_pc)
    );

    rg_fetch_guard #(.PC_W(PC_W), .PROG_TOP(PROG_TOP)) u_fetch (
        .clk(clk), .rst_n(rst_n),
        .op_fetch(op_fetch), .pc_addr(pc_addr), .pm_data(pm_data),
        .op_rpnd(op_rpnd), .overpop(overpop),
        .opcode_q(opcode), .pend_q(swi_pend), .cause_q(cause)
    );

    assign swi_cause = cause;
endmodule

// File: tb/runaway_guard_test.sv
module runaway_guard_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        op_call, op_intr, op_ret, op_push, op_pop, op_rd;
    logic        op_fetch, op_rpnd, sp_wr;
    logic [7:0]  sp_wdata, push_data;
    logic [14:0] pc_addr;
    logic [10:0] rd_addr;
    logic [7:0]  pm_data;
    logic [7:0]  opcode, rd_data, sp;
    logic [14:0] ret_pc;
    logic        swi_pend;
    logic [1:0]  swi_cause;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    // Programmed array content seen by the block: a fixed function of the address.
    assign pm_data = pc_addr[7:0] ^ 8'h5A;

    runaway_guard uut (
        .clk(clk), .rst_n(rst_n),
        .op_call(op_call), .op_intr(op_intr), .op_ret(op_ret),
        .op_push(op_push), .op_pop(op_pop), .op_rd(op_rd),
        .op_fetch(op_fetch), .op_rpnd(op_rpnd), .sp_wr(sp_wr),
        .sp_wdata(sp_wdata), .push_data(push_data), .pc_addr(pc_addr),
        .rd_addr(rd_addr), .pm_data(pm_data),
        .opcode(opcode), .rd_data(rd_data), .ret_pc(ret_pc), .sp(sp),
        .swi_pend(swi_pend), .swi_cause(swi_cause)
    );

    // Vector: {kind[1:0], arg[15:0], exp_byte[7:0], exp_sp[7:0]}
    // kind 0 push arg, 1 pop, 2 read arg, 3 fetch arg
    localparam logic [33:0] VEC [0:12] = '{
        {2'd0, 16'h0011, 8'h00, 8'h6E},
        {2'd0, 16'h0022, 8'h00, 8'h6D},
        {2'd2, 16'h006F, 8'h11, 8'h6D},
        {2'd2, 16'h006E, 8'h22, 8'h6D},
        {2'd2, 16'h0070, 8'hFF, 8'h6D},
        {2'd2, 16'h007F, 8'hFF, 8'h6D},
        {2'd2, 16'h0200, 8'hFF, 8'h6D},
        {2'd2, 16'h0085, 8'h00, 8'h6D},
        {2'd1, 16'h0000, 8'h22, 8'h6E},
        {2'd1, 16'h0000, 8'h11, 8'h6F},
        {2'd3, 16'h0123, 8'h79, 8'h6F},
        {2'd3, 16'h3FFF, 8'hA5, 8'h6F},
        {2'd2, 16'h07FF, 8'hFF, 8'h6F}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        op_call = 0; op_intr = 0; op_ret = 0; op_push = 0; op_pop = 0;
        op_rd = 0; op_fetch = 0; op_rpnd = 0; sp_wr = 0;
    endtask

    // One operation cycle: strobes set after a falling edge, results read at the next.
    task automatic cyc();
        @(negedge clk);
        idle();
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic do_fetch(input logic [14:0] a);
        pc_addr = a; op_fetch = 1; cyc();
    endtask

    task automatic do_read(input logic [10:0] a);
        rd_addr = a; op_rd = 1; cyc();
    endtask

    task automatic do_rpnd();
        op_rpnd = 1; cyc();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        idle();
        sp_wdata = '0; push_data = '0; pc_addr = '0; rd_addr = '0;
        @(negedge clk);
        do_reset();

        // R1: reset state
        check("R1 sp", sp, 8'h6F);
        check("R1 pend", swi_pend, 0);
        check("R1 cause", swi_cause, 0);
        check("R1 opcode", opcode, 0);
        check("R1 rd_data", rd_data, 0);
        check("R1 ret_pc", ret_pc, 0);

        // Vector walk: R2 push/pop, R4 reads, R5 programmed fetch
        for (int i = 0; i < 13; i++) begin
            case (VEC[i][33:32])
                2'd0: begin push_data = VEC[i][23:16]; op_push = 1; cyc(); end
                2'd1: begin op_pop = 1; cyc(); check("R2 pop data", rd_data, VEC[i][15:8]); end
                2'd2: begin do_read(VEC[i][26:16]); check("R4 read data", rd_data, VEC[i][15:8]); end
                default: begin
                    do_fetch(VEC[i][30:16]);
                    check("R5 opcode", opcode, VEC[i][15:8]);
                    check("R5 no trap", swi_pend, 0);
                end
            endcase
            check("R2 sp track", sp, VEC[i][7:0]);
        end

        // R3: call stores high byte above low byte, return restores
        pc_addr = 15'h1234; op_call = 1; cyc();
        check("R3 call sp", sp, 8'h6D);
        do_read(11'h06F); check("R3 high byte", rd_data, 8'h12);
        do_read(11'h06E); check("R3 low byte", rd_data, 8'h34);
        op_ret = 1; cyc();
        check("R3 ret_pc", ret_pc, 15'h1234);
        check("R3 ret sp", sp, 8'h6F);
        pc_addr = 15'h2A5C; op_intr = 1; cyc();
        check("R3 intr sp", sp, 8'h6D);
        do_read(11'h06F); check("R3 intr high", rd_data, 8'h2A);
        op_ret = 1; cyc();
        check("R3 intr ret_pc", ret_pc, 15'h2A5C);

        // R6 and R10: unprogrammed fetch, hold, clear
        do_fetch(15'h4000);
        check("R6 opcode", opcode, 8'h00);
        check("R6 pend", swi_pend, 1);
        check("R6 cause", swi_cause, 2'b01);
        do_fetch(15'h0100);
        check("R5 opcode while pending", opcode, 8'h5A);
        check("R10 pend held", swi_pend, 1);
        check("R10 cause held", swi_cause, 2'b01);
        do_rpnd();
        check("R10 cleared pend", swi_pend, 0);
        check("R10 cleared cause", swi_cause, 0);
        pc_addr = 15'h4000; op_fetch = 1; op_rpnd = 1; cyc();
        check("R10 trap beats clear", swi_pend, 1);
        check("R10 trap beats clear cause", swi_cause, 2'b01);
        do_rpnd();

        // R8 and R7: over-pop via pop, then trap at the option address
        op_pop = 1; cyc();
        check("R8 empty pop data", rd_data, 8'hFF);
        check("R8 sp", sp, 8'h70);
        do_fetch(15'h7FFF);
        check("R7 opcode", opcode, 8'h00);
        check("R7 pend", swi_pend, 1);
        check("R7 cause overpop", swi_cause, 2'b10);
        do_rpnd();

        // R8: return with empty stack vectors to all ones
        op_ret = 1; cyc();
        check("R8 ret_pc all ones", ret_pc, 15'h7FFF);
        check("R8 ret sp", sp, 8'h72);
        do_fetch(ret_pc);
        check("R7 cause after ret", swi_cause, 2'b10);
        do_rpnd();

        // R11: push above the stack area is dropped
        push_data = 8'h99; op_push = 1; cyc();
        check("R11 sp", sp, 8'h71);
        do_read(11'h072);
        check("R11 dropped write", rd_data, 8'hFF);

        // R12 and R9: pointer rewrite clears the over-pop flag
        sp_wdata = 8'h6F; sp_wr = 1; cyc();
        check("R12 sp loaded", sp, 8'h6F);
        do_fetch(15'h7FFF);
        check("R9 cause after rewrite", swi_cause, 2'b01);
        check("R7 pend", swi_pend, 1);
        do_rpnd();

        // R9 and R1: reset also clears the flag and a pending trap
        op_pop = 1; cyc();
        do_fetch(15'h4000);
        check("R6 pend before reset", swi_pend, 1);
        do_reset();
        check("R1 pend after reset", swi_pend, 0);
        check("R1 cause after reset", swi_cause, 0);
        check("R1 sp after reset", sp, 8'h6F);
        do_fetch(15'h7FFF);
        check("R9 cause after reset", swi_cause, 2'b01);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule